// File: doc/BRIEF.md
# Sixteen-Entry Lookup CAM with LRU Replacement Hint

This block is a small content-addressable memory. It has sixteen entries. Each entry holds a 32-bit tag, four state bits and a valid flag. A lookup compares a 32-bit key against every valid entry in the same cycle. One cycle later the block presents a packed 32-bit result word that carries the match outcome, the entry number and that entry's state.

The block also tracks how recently each entry was used. When a lookup finds nothing, the entry number it returns is the least recently used entry. Software can then take that entry as the slot to refill. A write port loads a tag and its state into a chosen entry. A clear command drops every entry at once.

For each lookup the caller may also ask for the result to be copied into a separate local-memory address register. That register is an output of the block and keeps its value until the next lookup that asks for a copy.

Top module: `lru_cam`

## Requirements
- R1: A write loads `wr_tag` and `wr_state` into entry `wr_idx` and marks that entry valid. All entries are invalid after reset.
- R2: The result word holds the state in bits 11:8, the hit flag in bit 7 (1 = hit) and the entry number in bits 6:3. Bits 31:12 and 2:0 are always zero.
- R3: On a hit the entry number is the matching valid entry and the state bits are that entry's stored state. When several valid entries match, the lowest-numbered one is reported.
- R4: On a miss the hit bit is 0, the state bits are 0000 and the entry number is the least recently used entry.
- R5: The recency order resets to entry 0 as least recent through entry 15 as most recent. A write or a hit makes the touched entry most recent and keeps the relative order of the others. A miss leaves the order unchanged.
- R6: `res_valid` is high in exactly the cycle after an accepted lookup request. `res_word` changes only at that point and otherwise holds its last value.
- R7: When a lookup is made with `lkp_to_lm` high, `lm_addr` takes the same value as `res_word` in the following cycle. Otherwise `lm_addr` holds its value.
- R8: A clear makes every entry invalid, so no later lookup hits until an entry is written again. A clear does not change the recency order.
- R9: After reset `res_valid` is 0, and both `res_word` and `lm_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_req | input | 1 | Start a lookup this cycle |
| lkp_key | input | 32 | Key to compare against the entries |
| lkp_to_lm | input | 1 | Also copy this lookup's result into `lm_addr` |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Entry to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State bits to store |
| clr_all | input | 1 | Invalidate all entries |
| res_valid | output | 1 | A lookup result is presented this cycle |
| res_word | output | 32 | Packed lookup result |
| lm_addr | output | 32 | Local-memory address register copy of a result |

## Verification
The assertions assume that in any cycle at most one of lookup, write and clear is requested. The RTL resolves a collision with a fixed priority, clear over write over lookup, but the properties about result timing are written only for the case where no collision occurs. The bench drives one operation per cycle and leaves an idle cycle between operations, so it never issues a collision. Its lookup keys are always either a tag it knows it wrote or a value it has confirmed is absent from its model. That way the expected hit or miss outcome is fixed before each request.

// File: rtl/lru_cam_pkg.sv
package lru_cam_pkg;
  // Bit position of the entry number inside the packed result word
  localparam int unsigned RES_IDX_LSB = 3;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_WRITE  = 2'd2,
    OP_CLEAR  = 2'd3
  } cam_op_e;
endpackage

// File: rtl/lru_cam_match.sv
module lru_cam_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [TAG_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  // Scan from the top down so the lowest-numbered match wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_cam_order.sv
module lru_cam_order #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);
  // Slot 0 holds the least recent entry, the top slot the most recent
  logic [ENTRIES-1:0][IDX_W-1:0] ord_q, ord_d;
  logic                          found;

  always_comb begin
    ord_d = ord_q;
    found = 1'b0;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES - 1; i++) begin
        if (ord_q[i] == touch_idx) found = 1'b1;
        if (found) ord_d[i] = ord_q[i+1];
      end
      ord_d[ENTRIES-1] = touch_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ord_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      ord_q <= ord_d;
    end
  end

  assign lru_idx = ord_q[0];
endmodule

// File: rtl/lru_cam.sv
module lru_cam
  import lru_cam_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 32,
  parameter int unsigned STATE_W = 4,
  parameter int unsigned RES_W   = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned HIT_POS = RES_IDX_LSB + IDX_W,
  localparam int unsigned ST_LSB  = HIT_POS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lkp_req,
  input  logic [TAG_W-1:0]   lkp_key,
  input  logic               lkp_to_lm,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [STATE_W-1:0] wr_state,
  input  logic               clr_all,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_word,
  output logic [RES_W-1:0]   lm_addr
);
  cam_op_e op;

  logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
  logic [ENTRIES-1:0][STATE_W-1:0] st_q;
  logic [ENTRIES-1:0]              vld_q, vld_d;
  logic [ENTRIES-1:0]              ent_we;

  logic             hit;
  logic [IDX_W-1:0] hit_idx, lru_idx, touch_idx;
  logic             touch_en;

  logic [RES_W-1:0] res_next;
  logic             res_valid_d;
  logic [RES_W-1:0] res_word_d, lm_d;
  logic             res_we, lm_we;

  // Fixed priority when requests collide: clear, then write, then lookup
  always_comb begin
    if (clr_all)      op = OP_CLEAR;
    else if (wr_en)   op = OP_WRITE;
    else if (lkp_req) op = OP_LOOKUP;
    else              op = OP_IDLE;
  end

  lru_cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .tags    (tag_q),
    .valid   (vld_q),
    .key     (lkp_key),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  assign touch_en  = (op == OP_WRITE) || ((op == OP_LOOKUP) && hit);
  assign touch_idx = (op == OP_WRITE) ? wr_idx : hit_idx;

  lru_cam_order #(.ENTRIES(ENTRIES)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  // Entry storage: per-entry write enables, valid bits with clear
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign ent_we[g] = (op == OP_WRITE) && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[g] <= '0;
          st_q[g]  <= '0;
        end else if (ent_we[g]) begin
          tag_q[g] <= wr_tag;
          st_q[g]  <= wr_state;
        end
      end
    end
  endgenerate

  always_comb begin
    vld_d = vld_q;
    if (op == OP_CLEAR) vld_d = '0;
    else                vld_d = vld_q | ent_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Result packing
  always_comb begin
    res_next = '0;
    if (hit) begin
      res_next[ST_LSB +: STATE_W]    = st_q[hit_idx];
      res_next[HIT_POS]              = 1'b1;
      res_next[RES_IDX_LSB +: IDX_W] = hit_idx;
    end else begin
      res_next[RES_IDX_LSB +: IDX_W] = lru_idx;
    end
  end

  assign res_we      = (op == OP_LOOKUP);
  assign lm_we       = res_we && lkp_to_lm;
  assign res_valid_d = res_we;
  assign res_word_d  = res_we ? res_next : res_word;
  assign lm_d        = lm_we ? res_next : lm_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      lm_addr   <= '0;
    end else begin
      res_valid <= res_valid_d;
      res_word  <= res_word_d;
      lm_addr   <= lm_d;
    end
  end
endmodule

// File: rtl/lru_cam_chk.sv
module lru_cam_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lkp_req,
  input logic        lkp_to_lm,
  input logic        wr_en,
  input logic        clr_all,
  input logic        res_valid,
  input logic [31:0] res_word,
  input logic [31:0] lm_addr
);
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkp_req, wr_en, clr_all}));                                         // R6
  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_word[31:12] == 20'h0) && (res_word[2:0] == 3'h0));          // R2
  AST_MISS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_word[7]) |-> (res_word[11:8] == 4'h0));                     // R4
  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && !wr_en && !clr_all) |=> res_valid);                                // R6
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> (!res_valid && $stable(res_word)));                              // R6
  AST_LM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && lkp_to_lm && !wr_en && !clr_all) |=> (lm_addr == res_word));       // R7
  AST_LM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_req && lkp_to_lm) |=> $stable(lm_addr));                                // R7
  AST_CLR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all ##1 lkp_req) |=> !res_word[7]);                                       // R8
endmodule

bind lru_cam lru_cam_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lkp_req   (lkp_req),
  .lkp_to_lm (lkp_to_lm),
  .wr_en     (wr_en),
  .clr_all   (clr_all),
  .res_valid (res_valid),
  .res_word  (res_word),
  .lm_addr   (lm_addr)
);

// File: tb/lru_cam_tb_top.sv
module lru_cam_tb_top;
  logic        clk;
  logic        rst_n;
  logic        lkp_req, lkp_to_lm, wr_en, clr_all;
  logic [31:0] lkp_key, wr_tag;
  logic [3:0]  wr_idx, wr_state;
  logic        res_valid;
  logic [31:0] res_word, lm_addr;

  int n_vec;
  int n_bad;

  // Reference model
  logic [31:0] m_tag [16];
  logic [3:0]  m_st  [16];
  logic        m_val [16];
  logic [3:0]  m_ord [16];
  logic [31:0] m_lm;

  lru_cam dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_key(lkp_key),
    .lkp_to_lm(lkp_to_lm), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_state(wr_state), .clr_all(clr_all), .res_valid(res_valid),
    .res_word(res_word), .lm_addr(lm_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_touch(input logic [3:0] idx);
    int p;
    p = 0;
    for (int i = 0; i < 16; i++) if (m_ord[i] == idx) p = i;
    for (int i = p; i < 15; i++) m_ord[i] = m_ord[i+1];
    m_ord[15] = idx;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [31:0] tag, input logic [3:0] st);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_state = st;
    @(negedge clk);
    wr_en = 1'b0;
    m_tag[idx] = tag; m_st[idx] = st; m_val[idx] = 1'b1;
    m_touch(idx);
    check("R6 no result after write", {31'h0, res_valid}, 32'h0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
    for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] key, input logic to_lm, input string req);
    logic [31:0] exp;
    int          hi;
    hi = -1;
    for (int i = 15; i >= 0; i--) if (m_val[i] && m_tag[i] == key) hi = i;
    if (hi >= 0) exp = {20'h0, m_st[hi], 1'b1, 4'(hi), 3'b000};
    else         exp = {20'h0, 4'h0, 1'b0, m_ord[0], 3'b000};
    @(negedge clk);
    lkp_req = 1'b1; lkp_key = key; lkp_to_lm = to_lm;
    @(negedge clk);
    lkp_req = 1'b0; lkp_to_lm = 1'b0;
    if (hi >= 0) m_touch(4'(hi));
    if (to_lm) m_lm = exp;
    check("R6 result valid", {31'h0, res_valid}, 32'h1);
    check(req, res_word, exp);
    check("R7 lm_addr", lm_addr, m_lm);
    @(negedge clk);
    check("R6 valid drops", {31'h0, res_valid}, 32'h0);
    check("R6 word holds", res_word, exp);
  endtask

  function automatic logic [31:0] tag_of(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    lkp_req = 0; lkp_to_lm = 0; wr_en = 0; clr_all = 0;
    lkp_key = '0; wr_tag = '0; wr_idx = '0; wr_state = '0;
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_st[i] = '0; m_ord[i] = 4'(i);
    end
    m_lm = '0;
    repeat (3) @(negedge clk);
    check("R9 reset res_valid", {31'h0, res_valid}, 32'h0);
    check("R9 reset res_word", res_word, 32'h0);
    check("R9 reset lm_addr", lm_addr, 32'h0);
    rst_n = 1'b1;

    // Empty CAM: all miss, LRU is entry 0 (R1, R8)
    do_lookup(32'h0, 1'b1, "R1 empty miss");
    do_lookup(tag_of(3), 1'b0, "R4 empty miss");

    // Fill all entries in a scrambled order (R1, R5)
    for (int i = 0; i < 16; i++) begin
      int e;
      e = (i * 7 + 5) % 16;
      do_write(4'(e), tag_of(e), 4'(e) ^ 4'h5);
    end

    // Hit every entry in another order (R3, R5, R7)
    for (int i = 0; i < 16; i++) begin
      int e;
      e = (i * 5 + 3) % 16;
      do_lookup(tag_of(e), 1'(i), "R3 hit");
    end

    // Misses report LRU and do not move it (R4, R5)
    for (int i = 0; i < 6; i++) do_lookup(32'h5A5A_0000 + 32'(i), 1'(i), "R4 miss LRU");

    // Interleave hits and misses to walk the recency order (R5)
    for (int i = 0; i < 8; i++) begin
      do_lookup(tag_of((i * 3) % 16), 1'b0, "R5 hit reorder");
      do_lookup(32'hDEAD_0000 + 32'(i), 1'b1, "R5 miss after reorder");
    end

    // Duplicate tags: lowest entry wins (R3)
    do_write(4'd9, tag_of(4), 4'hA);
    do_lookup(tag_of(4), 1'b1, "R3 duplicate lowest");
    do_write(4'd2, tag_of(11), 4'h3);
    do_lookup(tag_of(11), 1'b0, "R3 duplicate lowest");
    do_lookup(32'hFFFF_FFFF, 1'b0, "R4 miss LRU");

    // Clear: nothing hits, order kept (R8)
    do_clear();
    for (int i = 0; i < 16; i++) do_lookup(tag_of(i), 1'(i & 1), "R8 miss after clear");

    // Rewrite after clear (R1)
    do_write(4'd6, 32'h1234_5678, 4'hF);
    do_lookup(32'h1234_5678, 1'b1, "R1 hit after rewrite");
    do_lookup(tag_of(7), 1'b0, "R8 stale entry stays invalid");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog R6 actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule